// File: doc/BRIEF.md
# SPI Segmented Frame Builder

This block prepares and runs the byte payload of one SPI frame made of up to two segments, a leading segment (N1) and a trailing segment (N2). On a start command it captures the segment settings and a 64-bit transmit data register (TDR) image. It checks whether the frame may proceed. It then fills a 16-byte transmit FIFO one byte per cycle, either with TDR bytes or with 0xFF filler. The bytes go out to an external shifter in words of 1 to 4 bytes. Each word the shifter returns is split back into bytes, which are pushed into a 16-byte receive FIFO that the host drains.

Each segment has its own enable, requested byte count, transmit flag and receive flag. A lone N1 frame is started with only N1 enabled. A merged frame enables both segments, and the N2 bytes then follow the N1 bytes in the same payload. The frame does not start if a receiving segment finds the receive data register still full, or if a transmitting N1 finds the TDR empty. In both cases the block signals a halt instead. Status flags describe the most recent frame and stay valid until the next start.

Top module: `spi_frame_builder`

## Requirements
- R1: After a synchronous reset: `sh_valid`, `done`, `halt`, `tdr_clr`, `busy` and every status flag are 0, and `rx_level` is 0.
- R2: Byte j of the N1 segment (j counted from 0) is TDR byte j when N1 transmits and j < 8; otherwise it is 0xFF. TDR byte 0 is `tdr[63:56]` and byte 7 is `tdr[7:0]`.
- R3: In N2, byte i reads TDR offset T+i. T is the N1 byte count when N1 is enabled and transmitting, and 0 otherwise. The TDR byte is used only when N2 transmits and T+i < 8; otherwise the byte is 0xFF. N2 bytes follow all N1 bytes.
- R4: The transmit FIFO holds 16 bytes. Payload bytes beyond 16 are dropped and `tx_ovf` is set. Only the stored bytes are sent.
- R5: Each shifter word carries L bytes, where L is `xfer_len` sampled at start, with 0 read as 1 and values above 4 read as 4. The first payload byte sits in the most significant of the L bytes, right-aligned in `sh_word`. The unused upper bits and the padding bytes of a partial last word are zero.
- R6: The L bytes of each returned `rsp_word` are taken most significant first and pushed into the receive FIFO. Only bytes whose payload position is below the sent length are pushed. The host reads the FIFO through `rx_data`, `rx_pop` and `rx_level`.
- R7: If the receive FIFO (16 bytes) is full when a byte is due, that byte and the rest of its word are dropped and `rx_ovf` is set.
- R8: A requested count above the limit is clamped to the limit and sets `size_err`. The limit is 9 when `ecc_mode` is 0 or 2, and 8 otherwise. Disabled segments count as 0 bytes.
- R9: If `rdr_full` is 1 and an enabled segment with a nonzero count has its receive flag set, `halt` pulses two clock edges after `start` is sampled, and no word is offered.
- R10: If N1 is enabled, transmitting, has a nonzero count and `tdr_full` is 0, `halt` pulses and `underrun` is set at the same edge. This check takes priority over R9.
- R11: A frame that is sent ends with a one-cycle `done` pulse. When N2 is enabled and transmitting and `tdr_full` is 1, `tdr_clr` pulses with `done`. A frame with an empty payload reaches `done` without offering a word.
- R12: While `sh_valid` is 1 and `sh_ready` is 0, `sh_valid` stays 1 and `sh_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a frame (accepted when idle) |
| xfer_len | input | 3 | Bytes per shifter word, sampled at start |
| ecc_mode | input | 2 | Selects the segment size limit |
| n1_en | input | 1 | Enable leading segment |
| n1_cnt | input | 4 | Requested N1 byte count |
| n1_tx | input | 1 | N1 transmits TDR data |
| n1_rx | input | 1 | N1 receives |
| n2_en | input | 1 | Enable trailing segment |
| n2_cnt | input | 4 | Requested N2 byte count |
| n2_tx | input | 1 | N2 transmits TDR data |
| n2_rx | input | 1 | N2 receives |
| tdr | input | 64 | Transmit data register, captured at start |
| tdr_full | input | 1 | TDR holds data |
| rdr_full | input | 1 | Receive data register not yet unloaded |
| sh_valid | output | 1 | Word offered to shifter |
| sh_ready | input | 1 | Shifter accepts the word |
| sh_word | output | 32 | Outgoing word |
| rsp_valid | input | 1 | Returned word strobe |
| rsp_word | input | 32 | Returned word |
| rx_pop | input | 1 | Remove head of receive FIFO |
| rx_data | output | 8 | Head of receive FIFO |
| rx_level | output | 5 | Receive FIFO occupancy |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame completed pulse |
| halt | output | 1 | Frame refused pulse |
| tdr_clr | output | 1 | Request to clear TDR-full |
| underrun | output | 1 | N1 transmit found TDR empty |
| size_err | output | 1 | A segment count was clamped |
| tx_ovf | output | 1 | Transmit FIFO overflowed |
| rx_ovf | output | 1 | Receive FIFO overflowed |

## Verification
A refused frame shows `halt` exactly two edges after `start` is sampled, so the bench samples it at the second falling edge and nowhere else. A sent frame takes a variable number of cycles: one per payload byte to fill, then per word one cycle per byte to pack, the handshake, the response wait and up to L cycles to unpack. For that reason word contents are checked at each `sh_valid` handshake, and the frame outcome and flags are checked in the single cycle of `done`. Receive bytes are compared after `done`, with one pop per cycle, and `rx_level` and `rx_data` are checked at each falling edge against a queue model that applies the overflow and per-word drop rules.

// File: rtl/spi_fb_pkg.sv
// Package: shared state encoding for the SPI segmented frame builder.
// Assumes: one sequencer instance owns the encoding.
package spi_fb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FILL,
        ST_PACK,
        ST_OFFER,
        ST_WAIT,
        ST_UNPACK,
        ST_DONE
    } fb_state_e;

endpackage

// File: rtl/spi_fb_byte_fifo.sv
// Module: byte-wide synchronous FIFO with first-word-fall-through head.
// Assumes: a push while full and a pop while empty are ignored; the caller
// gates them and derives its own error flags.
module spi_fb_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/spi_fb_seg_plan.sv
// Module: clamps the two segment byte counts against the size limit chosen
// by the ECC mode and derives the lengths the sequencer uses.
// Assumes: purely combinational; inputs are already captured for the frame.
module spi_fb_seg_plan #(
    parameter int CNT_W     = 4,
    parameter int TDR_BYTES = 8
) (
    input  logic [1:0]       ecc_mode,
    input  logic             n1_en,
    input  logic             n2_en,
    input  logic             n1_tx,
    input  logic [CNT_W-1:0] n1_req,
    input  logic [CNT_W-1:0] n2_req,
    output logic [CNT_W-1:0] n1_len,
    output logic [CNT_W-1:0] n2_len,
    output logic [CNT_W-1:0] n1_tx_len,
    output logic [CNT_W:0]   total_len,
    output logic             size_err
);

    logic [CNT_W-1:0] limit;
    logic             en_a   [2];
    logic [CNT_W-1:0] req_a  [2];
    logic [CNT_W-1:0] len_a  [2];
    logic [1:0]       over_a;

    // Size limit: one extra byte when ECC mode is 0 or 2.
    always_comb begin
        if (ecc_mode == 2'd0 || ecc_mode == 2'd2) begin
            limit = CNT_W'(TDR_BYTES + 1);
        end else begin
            limit = CNT_W'(TDR_BYTES);
        end
    end

    assign en_a[0]  = n1_en;
    assign en_a[1]  = n2_en;
    assign req_a[0] = n1_req;
    assign req_a[1] = n2_req;

    for (genvar s = 0; s < 2; s++) begin : g_seg
        // Per-segment clamp; disabled segments contribute no bytes.
        assign over_a[s] = en_a[s] && (req_a[s] > limit);
        assign len_a[s]  = !en_a[s] ? '0 : (over_a[s] ? limit : req_a[s]);
    end

    assign n1_len    = len_a[0];
    assign n2_len    = len_a[1];
    assign n1_tx_len = n1_tx ? len_a[0] : '0;
    assign total_len = {1'b0, len_a[0]} + {1'b0, len_a[1]};
    assign size_err  = |over_a;

endmodule

// File: rtl/spi_fb_byte_src.sv
// Module: selects the payload byte at a given frame position: a TDR byte
// for transmitting positions inside the register, 0xFF filler otherwise.
// Assumes: TDR byte 0 is the most significant byte of the register image.
module spi_fb_byte_src #(
    parameter int CNT_W     = 4,
    parameter int TDR_BYTES = 8,
    localparam int IDX_W    = CNT_W + 1,
    localparam int OW       = CNT_W + 2,
    localparam int DW       = 8 * TDR_BYTES
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] n1_len,
    input  logic [CNT_W-1:0] n1_tx_len,
    input  logic             n1_tx,
    input  logic             n2_tx,
    input  logic [DW-1:0]    tdr,
    output logic [7:0]       byte_o
);

    logic [OW-1:0] off;
    logic          take;
    logic [DW-1:0] shifted;

    // Map frame position to TDR offset and decide whether data is taken.
    always_comb begin
        if (OW'(idx) < OW'(n1_len)) begin
            off  = OW'(idx);
            take = n1_tx;
        end else begin
            off  = OW'(n1_tx_len) + (OW'(idx) - OW'(n1_len));
            take = n2_tx;
        end
        shifted = '0;
        byte_o  = 8'hFF;
        if (take && (off < OW'(TDR_BYTES))) begin
            shifted = tdr >> (8 * (TDR_BYTES - 1 - int'(off)));
            byte_o  = shifted[7:0];
        end
    end

endmodule

// File: rtl/spi_frame_builder.sv
// Module: SPI segmented frame builder. Captures segment settings and the
// TDR image at start, decides between halting and sending, fills the
// transmit FIFO byte by byte, packs words MSB-first for the shifter and
// unpacks returned words into the receive FIFO.
// Assumes: the shifter answers every accepted word with exactly one
// rsp_valid strobe; start is ignored while a frame is in progress.
module spi_frame_builder
    import spi_fb_pkg::*;
#(
    parameter int TDR_BYTES  = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_XFER   = 4,
    parameter int CNT_W      = 4,
    localparam int XL_W      = $clog2(MAX_XFER + 1),
    localparam int WORD_W    = 8 * MAX_XFER,
    localparam int DW        = 8 * TDR_BYTES,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XL_W-1:0]   xfer_len,
    input  logic [1:0]        ecc_mode,
    input  logic              n1_en,
    input  logic [CNT_W-1:0]  n1_cnt,
    input  logic              n1_tx,
    input  logic              n1_rx,
    input  logic              n2_en,
    input  logic [CNT_W-1:0]  n2_cnt,
    input  logic              n2_tx,
    input  logic              n2_rx,
    input  logic [DW-1:0]     tdr,
    input  logic              tdr_full,
    input  logic              rdr_full,
    output logic              sh_valid,
    input  logic              sh_ready,
    output logic [WORD_W-1:0] sh_word,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              rx_pop,
    output logic [7:0]        rx_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              busy,
    output logic              done,
    output logic              halt,
    output logic              tdr_clr,
    output logic              underrun,
    output logic              size_err,
    output logic              tx_ovf,
    output logic              rx_ovf
);

    localparam int IDX_W = CNT_W + 1;
    localparam int PW    = $clog2(FIFO_DEPTH + MAX_XFER + 1) + 1;

    fb_state_e         state;
    logic              n1_en_q, n1_tx_q, n1_rx_q;
    logic              n2_en_q, n2_tx_q, n2_rx_q;
    logic [CNT_W-1:0]  n1_cnt_q, n2_cnt_q;
    logic [1:0]        ecc_q;
    logic [DW-1:0]     tdr_q;
    logic [XL_W-1:0]   xlen_q;
    logic [XL_W-1:0]   xlen_eff;
    logic [IDX_W-1:0]  fill_idx;
    logic [LVL_W-1:0]  pay_len;
    logic [PW-1:0]     base;
    logic [XL_W-1:0]   k;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] rsp_q;
    logic [WORD_W-1:0] rsp_sh;
    logic              done_q, halt_q, clr_q;
    logic              und_q, size_q, txovf_q, rxovf_q;

    logic [CNT_W-1:0]  n1_len, n2_len, n1_tx_len;
    logic [CNT_W:0]    total_len;
    logic              plan_size_err;
    logic [7:0]        src_byte;

    logic              tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]        tx_head;
    logic [LVL_W-1:0]  tx_level;
    logic              rx_push, rx_full, rx_empty;

    logic              need_underrun, need_wait;
    logic              fill_end, in_range, unpack_end, last_k;
    logic [7:0]        pack_byte, rsp_byte;

    spi_fb_seg_plan #(.CNT_W(CNT_W), .TDR_BYTES(TDR_BYTES)) u_plan (
        .ecc_mode (ecc_q),
        .n1_en    (n1_en_q),
        .n2_en    (n2_en_q),
        .n1_tx    (n1_tx_q),
        .n1_req   (n1_cnt_q),
        .n2_req   (n2_cnt_q),
        .n1_len   (n1_len),
        .n2_len   (n2_len),
        .n1_tx_len(n1_tx_len),
        .total_len(total_len),
        .size_err (plan_size_err)
    );

    spi_fb_byte_src #(.CNT_W(CNT_W), .TDR_BYTES(TDR_BYTES)) u_src (
        .idx      (fill_idx),
        .n1_len   (n1_len),
        .n1_tx_len(n1_tx_len),
        .n1_tx    (n1_tx_q),
        .n2_tx    (n2_tx_q),
        .tdr      (tdr_q),
        .byte_o   (src_byte)
    );

    spi_fb_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_push),
        .push_data(src_byte),
        .pop      (tx_pop),
        .head     (tx_head),
        .full     (tx_full),
        .empty    (tx_empty),
        .level    (tx_level)
    );

    spi_fb_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_data(rsp_byte),
        .pop      (rx_pop),
        .head     (rx_data),
        .full     (rx_full),
        .empty    (rx_empty),
        .level    (rx_level)
    );

    // Saturate the requested word length into 1..MAX_XFER.
    always_comb begin
        if (xfer_len == '0) begin
            xlen_eff = XL_W'(1);
        end else if (xfer_len > XL_W'(MAX_XFER)) begin
            xlen_eff = XL_W'(MAX_XFER);
        end else begin
            xlen_eff = xfer_len;
        end
    end

    // Frame admission: underrun on a transmitting N1, wait on a full RDR.
    assign need_underrun = n1_tx_q && (n1_len != '0) && !tdr_full;
    assign need_wait     = rdr_full && ((n1_rx_q && (n1_len != '0)) ||
                                        (n2_rx_q && (n2_len != '0)));

    // Datapath strobes derived from the current state.
    assign fill_end   = (IDX_W'(fill_idx) == IDX_W'(total_len)) || tx_full;
    assign tx_push    = (state == ST_FILL) && !fill_end;
    assign in_range   = (base + PW'(k)) < PW'(pay_len);
    assign tx_pop     = (state == ST_PACK) && in_range && !tx_empty;
    assign pack_byte  = tx_pop ? tx_head : 8'h00;
    assign last_k     = (k == xlen_q - 1'b1);
    assign rx_push    = (state == ST_UNPACK) && in_range && !rx_full;
    assign unpack_end = last_k || !in_range || rx_full;

    // Select the response byte at position k, most significant first.
    always_comb begin
        rsp_sh   = rsp_q >> (8 * (int'(xlen_q) - 1 - int'(k)));
        rsp_byte = rsp_sh[7:0];
    end

    // Sequencer: admission, fill, pack, handshake, unpack, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            n1_en_q  <= 1'b0;
            n1_tx_q  <= 1'b0;
            n1_rx_q  <= 1'b0;
            n2_en_q  <= 1'b0;
            n2_tx_q  <= 1'b0;
            n2_rx_q  <= 1'b0;
            n1_cnt_q <= '0;
            n2_cnt_q <= '0;
            ecc_q    <= '0;
            tdr_q    <= '0;
            xlen_q   <= XL_W'(1);
            fill_idx <= '0;
            pay_len  <= '0;
            base     <= '0;
            k        <= '0;
            word_q   <= '0;
            rsp_q    <= '0;
            done_q   <= 1'b0;
            halt_q   <= 1'b0;
            clr_q    <= 1'b0;
            und_q    <= 1'b0;
            size_q   <= 1'b0;
            txovf_q  <= 1'b0;
            rxovf_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            halt_q <= 1'b0;
            clr_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        n1_en_q  <= n1_en;
                        n1_tx_q  <= n1_tx;
                        n1_rx_q  <= n1_rx;
                        n2_en_q  <= n2_en;
                        n2_tx_q  <= n2_tx;
                        n2_rx_q  <= n2_rx;
                        n1_cnt_q <= n1_cnt;
                        n2_cnt_q <= n2_cnt;
                        ecc_q    <= ecc_mode;
                        tdr_q    <= tdr;
                        xlen_q   <= xlen_eff;
                        und_q    <= 1'b0;
                        size_q   <= 1'b0;
                        txovf_q  <= 1'b0;
                        rxovf_q  <= 1'b0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    size_q <= plan_size_err;
                    if (need_underrun) begin
                        und_q  <= 1'b1;
                        halt_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (need_wait) begin
                        halt_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        fill_idx <= '0;
                        state    <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_end) begin
                        if (IDX_W'(fill_idx) != IDX_W'(total_len)) begin
                            txovf_q <= 1'b1;
                        end
                        pay_len <= tx_level;
                        base    <= '0;
                        k       <= '0;
                        word_q  <= '0;
                        state   <= (tx_level == '0) ? ST_DONE : ST_PACK;
                    end else begin
                        fill_idx <= fill_idx + 1'b1;
                    end
                end
                ST_PACK: begin
                    word_q <= {word_q[WORD_W-9:0], pack_byte};
                    if (last_k) begin
                        k     <= '0;
                        state <= ST_OFFER;
                    end else begin
                        k <= k + 1'b1;
                    end
                end
                ST_OFFER: begin
                    if (sh_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        rsp_q <= rsp_word;
                        k     <= '0;
                        state <= ST_UNPACK;
                    end
                end
                ST_UNPACK: begin
                    if (in_range && rx_full) begin
                        rxovf_q <= 1'b1;
                    end
                    if (unpack_end) begin
                        base   <= base + PW'(xlen_q);
                        k      <= '0;
                        word_q <= '0;
                        state  <= ((base + PW'(xlen_q)) < PW'(pay_len)) ? ST_PACK : ST_DONE;
                    end else begin
                        k <= k + 1'b1;
                    end
                end
                ST_DONE: begin
                    done_q <= 1'b1;
                    clr_q  <= n2_en_q && n2_tx_q && tdr_full;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sh_valid = (state == ST_OFFER);
    assign sh_word  = word_q;
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign halt     = halt_q;
    assign tdr_clr  = clr_q;
    assign underrun = und_q;
    assign size_err = size_q;
    assign tx_ovf   = txovf_q;
    assign rx_ovf   = rxovf_q;

endmodule

// File: rtl/spi_fb_checker.sv
// Module: temporal checks on the frame builder ports, bound to the top.
// Assumes: sampled on the rising clock edge, disabled during reset.
module spi_fb_checker #(
    parameter int WORD_W     = 32,
    parameter int LVL_W      = 5,
    parameter int FIFO_DEPTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sh_valid,
    input logic              sh_ready,
    input logic [WORD_W-1:0] sh_word,
    input logic              done,
    input logic              halt,
    input logic              tdr_clr,
    input logic              underrun,
    input logic [LVL_W-1:0]  rx_level
);

    // R12: an offered word is held until the shifter takes it.
    a_r12_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_word)));

    // R9: a refused frame never offers a word in the halt cycle.
    a_r9_halt_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !sh_valid);

    // R11: a frame ends either sent or refused, never both.
    a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && halt));

    // R11: the TDR-clear request only accompanies completion.
    a_r11_clear_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_clr |-> done);

    // R10: the underrun flag appears together with the halt pulse.
    a_r10_underrun_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> halt);

    // R7: receive occupancy never exceeds the FIFO depth.
    a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(FIFO_DEPTH));

endmodule

bind spi_frame_builder spi_fb_checker #(
    .WORD_W    (WORD_W),
    .LVL_W     (LVL_W),
    .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sh_valid(sh_valid),
    .sh_ready(sh_ready),
    .sh_word (sh_word),
    .done    (done),
    .halt    (halt),
    .tdr_clr (tdr_clr),
    .underrun(underrun),
    .rx_level(rx_level)
);

// File: tb/spi_frame_builder_bench.sv
module spi_frame_builder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  xfer_len;
    logic [1:0]  ecc_mode;
    logic        n1_en, n1_tx, n1_rx, n2_en, n2_tx, n2_rx;
    logic [3:0]  n1_cnt, n2_cnt;
    logic [63:0] tdr;
    logic        tdr_full, rdr_full;
    logic        sh_valid, sh_ready;
    logic [31:0] sh_word;
    logic        rsp_valid;
    logic [31:0] rsp_word;
    logic        rx_pop;
    logic [7:0]  rx_data;
    logic [4:0]  rx_level;
    logic        busy, done, halt, tdr_clr, underrun, size_err, tx_ovf, rx_ovf;

    int          n_checks = 0;
    int          n_errs   = 0;
    int          cyc      = 0;
    int          eff_len  = 1;
    int          stall_ctr = 0;
    bit          frame_active = 1'b0;
    logic [31:0] exp_word_q [$];
    logic [7:0]  exp_rx_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_frame_builder u_spi_frame_builder (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .ecc_mode(ecc_mode), .n1_en(n1_en), .n1_cnt(n1_cnt), .n1_tx(n1_tx),
        .n1_rx(n1_rx), .n2_en(n2_en), .n2_cnt(n2_cnt), .n2_tx(n2_tx),
        .n2_rx(n2_rx), .tdr(tdr), .tdr_full(tdr_full), .rdr_full(rdr_full),
        .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_word(sh_word),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_level(rx_level), .busy(busy), .done(done),
        .halt(halt), .tdr_clr(tdr_clr), .underrun(underrun),
        .size_err(size_err), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
    );

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] tdr_byte(input logic [63:0] v, input int j);
        return 8'((v >> (8 * (7 - j))) & 64'hFF);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    // Every clock: no word may be offered outside a started frame (R9, R5).
    always @(negedge clk) begin
        if (rst_n && sh_valid && !frame_active) begin
            check(1'b0, "R9 word offered outside frame", 1, 0);
        end
    end

    // Shifter model: stalls on alternate words, answers with inverted bytes.
    initial begin
        logic [31:0] w;
        logic [31:0] exp;
        logic [31:0] mask;
        sh_ready  = 1'b0;
        rsp_valid = 1'b0;
        rsp_word  = '0;
        forever begin
            @(negedge clk);
            if (sh_valid) begin
                w = sh_word;
                if (exp_word_q.size() == 0) begin
                    check(1'b0, "R5 unexpected shifter word", w, 0);
                end else begin
                    exp = exp_word_q.pop_front();
                    check(w == exp, "R2/R3 R5 shifter word", w, exp);
                end
                stall_ctr++;
                if (stall_ctr % 2 == 1) begin
                    repeat (2) @(negedge clk);
                    check(sh_valid && sh_word == w, "R12 word held under stall", sh_word, w);
                end
                sh_ready = 1'b1;
                @(negedge clk);
                sh_ready = 1'b0;
                repeat (2) @(negedge clk);
                mask = (eff_len >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * eff_len)) - 32'd1);
                rsp_word  = ~w & mask;
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_frame(input string tag, input int xl, input int ecc,
                             input bit n1e, input int n1c, input bit n1t, input bit n1r,
                             input bit n2e, input int n2c, input bit n2t, input bit n2r,
                             input logic [63:0] tv, input bit tf, input bit rf);
        logic [7:0] pay [$];
        int  lim, l1, l2, t1, nw, idx, waited;
        bit  serr, und, rstop, txo, rxo, stop_word, got;
        logic [31:0] word;
        lim  = (ecc == 0 || ecc == 2) ? 9 : 8;
        l1   = n1e ? ((n1c > lim) ? lim : n1c) : 0;
        l2   = n2e ? ((n2c > lim) ? lim : n2c) : 0;
        serr = (n1e && n1c > lim) || (n2e && n2c > lim);
        eff_len = (xl == 0) ? 1 : ((xl > 4) ? 4 : xl);
        und   = n1e && n1t && l1 > 0 && !tf;
        rstop = rf && ((n1e && n1r && l1 > 0) || (n2e && n2r && l2 > 0));
        txo = 1'b0;
        rxo = 1'b0;
        if (!und && !rstop) begin
            for (int j = 0; j < l1; j++) pay.push_back((n1t && j < 8) ? tdr_byte(tv, j) : 8'hFF);
            t1 = (n1e && n1t) ? l1 : 0;
            for (int i = 0; i < l2; i++) pay.push_back((n2t && t1 + i < 8) ? tdr_byte(tv, t1 + i) : 8'hFF);
            txo = pay.size() > 16;
            while (pay.size() > 16) void'(pay.pop_back());
            nw = (pay.size() + eff_len - 1) / eff_len;
            for (int wi = 0; wi < nw; wi++) begin
                word = '0;
                stop_word = 1'b0;
                for (int kk = 0; kk < eff_len; kk++) begin
                    idx  = wi * eff_len + kk;
                    word = (word << 8) | ((idx < pay.size()) ? 32'(pay[idx]) : 32'd0);
                    if (idx < pay.size() && !stop_word) begin
                        if (exp_rx_q.size() >= 16) begin
                            rxo = 1'b1;
                            stop_word = 1'b1;
                        end else begin
                            exp_rx_q.push_back(~pay[idx]);
                        end
                    end
                end
                exp_word_q.push_back(word);
            end
        end
        @(negedge clk);
        xfer_len = 3'(xl);  ecc_mode = 2'(ecc);
        n1_en = n1e; n1_cnt = 4'(n1c); n1_tx = n1t; n1_rx = n1r;
        n2_en = n2e; n2_cnt = 4'(n2c); n2_tx = n2t; n2_rx = n2r;
        tdr = tv; tdr_full = tf; rdr_full = rf;
        start = 1'b1;
        frame_active = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (und || rstop) begin
            @(negedge clk);
            check(halt == 1'b1, {tag, " R9/R10 halt two edges after start"}, halt, 1);
            check(underrun == und, {tag, " R10 underrun flag"}, underrun, und);
            check(sh_valid == 1'b0, {tag, " R9 no word offered"}, sh_valid, 0);
            repeat (3) @(negedge clk);
            check(busy == 1'b0 && done == 1'b0, {tag, " R9 frame refused stays idle"}, busy, 0);
        end else begin
            got = 1'b0;
            waited = 0;
            while (!got && waited < 3000) begin
                @(negedge clk);
                waited++;
                if (done) got = 1'b1;
                if (halt) begin
                    check(1'b0, {tag, " R9 unexpected halt"}, 1, 0);
                    waited = 3000;
                end
            end
            check(got, {tag, " R11 done pulse"}, got, 1);
            check(tdr_clr == (n2e && n2t && tf), {tag, " R11 tdr_clr"}, tdr_clr, (n2e && n2t && tf));
            check(size_err == serr, {tag, " R8 size_err"}, size_err, serr);
            check(tx_ovf == txo, {tag, " R4 tx_ovf"}, tx_ovf, txo);
            check(rx_ovf == rxo, {tag, " R7 rx_ovf"}, rx_ovf, rxo);
            check(underrun == 1'b0, {tag, " R10 no underrun"}, underrun, 0);
            check(exp_word_q.size() == 0, {tag, " R5 all words sent"}, exp_word_q.size(), 0);
            exp_word_q.delete();
        end
        frame_active = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (exp_rx_q.size() > 0) begin
            check(rx_level == 5'(exp_rx_q.size()), {tag, " R6 rx level"}, rx_level, exp_rx_q.size());
            check(rx_data == exp_rx_q[0], {tag, " R6 rx byte"}, rx_data, exp_rx_q[0]);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            void'(exp_rx_q.pop_front());
        end
        check(rx_level == 0, {tag, " R6 rx empty after drain"}, rx_level, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; xfer_len = 3'd1; ecc_mode = 2'd1;
        n1_en = 0; n1_cnt = 0; n1_tx = 0; n1_rx = 0;
        n2_en = 0; n2_cnt = 0; n2_tx = 0; n2_rx = 0;
        tdr = '0; tdr_full = 0; rdr_full = 0; rx_pop = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sh_valid && !done && !halt && !tdr_clr && !busy, "R1 idle outputs", {sh_valid, done, halt, tdr_clr, busy}, 0);
        check(!underrun && !size_err && !tx_ovf && !rx_ovf, "R1 flags clear", {underrun, size_err, tx_ovf, rx_ovf}, 0);
        check(rx_level == 0, "R1 rx empty", rx_level, 0);

        // R2: lone N1 transmit, one full word.
        run_frame("n1_tx4", 4, 1, 1, 4, 1, 1, 0, 0, 0, 0, 64'h0123_4567_89AB_CDEF, 1, 0);
        drain("n1_tx4");
        // R3, R5: merged frame, N2 runs past the TDR end, partial last word.
        run_frame("merge", 2, 1, 1, 3, 1, 0, 1, 6, 1, 1, 64'h0123_4567_89AB_CDEF, 1, 0);
        drain("merge");
        // R2: N1 receive only gives filler bytes.
        run_frame("n1_rx", 3, 1, 1, 5, 0, 1, 0, 0, 0, 0, 64'hFEDC_BA98_7654_3210, 0, 0);
        drain("n1_rx");
        // R3: N2 alone starts at TDR offset 0.
        run_frame("n2_only", 4, 1, 0, 0, 0, 0, 1, 5, 1, 0, 64'hA1B2_C3D4_E5F6_0718, 1, 0);
        drain("n2_only");
        // R8: clamp to 8 with ECC mode 1, payload exactly 16.
        run_frame("clamp8", 4, 1, 1, 12, 1, 0, 1, 15, 0, 1, 64'h1122_3344_5566_7788, 1, 0);
        drain("clamp8");
        // R4, R8: clamp to 9 with ECC mode 0, 18 bytes overflow the FIFO.
        run_frame("clamp9", 3, 0, 1, 12, 1, 0, 1, 12, 1, 0, 64'h1122_3344_5566_7788, 1, 0);
        drain("clamp9");
        // R9: receiving segment with RDR still full.
        run_frame("rdr_wait", 2, 1, 1, 2, 0, 0, 1, 3, 0, 1, 64'h0, 1, 1);
        // R10: underrun wins over the RDR wait.
        run_frame("underrun", 2, 1, 1, 2, 1, 1, 0, 0, 0, 0, 64'h0, 0, 1);
        // R7: second frame overflows the undrained receive FIFO.
        run_frame("fill12", 4, 1, 1, 8, 0, 1, 1, 4, 0, 1, 64'h0, 0, 0);
        run_frame("rx_over", 3, 1, 1, 8, 1, 1, 0, 0, 0, 0, 64'h0F1E_2D3C_4B5A_6978, 1, 0);
        drain("R7 rx_over");
        // R5: word length 0 reads as 1, 7 reads as 4.
        run_frame("len0", 0, 1, 1, 3, 1, 0, 0, 0, 0, 0, 64'hC0FF_EE00_1234_5678, 1, 0);
        drain("len0");
        run_frame("len7", 7, 1, 1, 6, 1, 0, 0, 0, 0, 0, 64'hC0FF_EE00_1234_5678, 1, 0);
        drain("len7");
        // R11: N2 receive-only with TDR full gives no clear; empty payload.
        run_frame("n2_rx_noclr", 2, 1, 0, 0, 0, 0, 1, 2, 0, 1, 64'h0, 1, 0);
        drain("n2_rx_noclr");
        run_frame("empty", 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 64'h0, 0, 0);
        drain("empty");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule